// File: doc/BRIEF.md
# Handshake Line Status and Control Registers

This block gives a memory-mapped host a view of a pair of hardware handshake wires. The active-low clear-to-send wire coming in from the far end passes through a resynchronising register chain. Its level appears as a status bit. Any change of that level, in either direction, is caught in a sticky change flag. A control register lets the host drive the active-low request-to-send wire. It also lets the host allow an interrupt request whenever the change flag is set. The wires are tied only to these register bits and gate nothing else.

The host side is a single-cycle register port. A write takes effect at the clock edge where `host_wr` is high. A read is combinational from `host_addr`. There are no data streams, so every pin is a plain level. The parameter `FLOW_EN` removes the whole feature. In that case every bit reads 0, `rts_n` stays high and `irq` stays low.

Top module: `mfc_regs`

## Requirements
- R1: After reset both registers read 0, `rts_n` is 1 and `irq` is 0.
- R2: Status address 0, bit 0 (CTS) reads the inverse of `cts_n`. A change of the pin is seen on `host_rdata` after the second rising clock edge, not before.
- R3: Status address 0, bit 1 (DCTS) becomes 1 on the edge after CTS changes (the third edge after the pin change). It does so for both a rising and a falling change.
- R4: DCTS stays 1 until the host writes to address 0, whatever the write data. It clears at that write edge. If a new change is detected on the same edge, DCTS stays 1.
- R5: Control address 1 holds RTS in bit 0 and the interrupt enable in bit 1. Both read back as written, and all other bits read 0.
- R6: `rts_n` is the inverse of RTS and changes at the edge of the control write.
- R7: `irq` is 1 exactly while DCTS and the interrupt enable are both 1.
- R8: A write to address 0 leaves the control register unchanged. A write to address 1 does not clear DCTS.
- R9: With `FLOW_EN` = 0, both addresses read 0, `rts_n` is 1 and `irq` is 0 under any stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n | input | 1 | Clear-to-send wire, active low, asynchronous |
| rts_n | output | 1 | Request-to-send wire, active low |
| irq | output | 1 | Interrupt request on a latched CTS change |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_addr | input | 1 | Register select: 0 status, 1 control |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data of the selected register |

## Verification
Each result has its own latency:
- CTS is due two edges after a pin change.
- DCTS and `irq` are due three edges after a pin change.
- A write to RTS, the interrupt enable or the DCTS clear shows on the first edge.
- Read data is combinational with the address.

A directed sequence samples on the falling clock edge after each of those rising edges, and checks that the value has not yet moved one edge earlier. Random traffic is compared every cycle against a bench model that advances at the same rising edge as the design. Inputs are driven and outputs read only on the falling edge.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_CTRL   = 1'b1;
  localparam int   BIT_CTS     = 0;
  localparam int   BIT_DCTS    = 1;
  localparam int   BIT_RTS     = 0;
  localparam int   BIT_IE      = 1;
endpackage

// File: rtl/mfc_sync.sv
module mfc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[i] <= RST_VAL;
        else        chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mfc_delta.sv
module mfc_delta (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic clr,
  output logic flag
);
  logic prev_q;
  logic change;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= level;

  assign change = level ^ prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      flag <= 1'b0;
    else if (change) flag <= 1'b1;
    else if (clr)    flag <= 1'b0;

  a_r3_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (level != prev_q) |=> flag);
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  a_r4_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !change) |=> !flag);
endmodule

// File: rtl/mfc_ctrl.sv
module mfc_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rts,
  output logic              ie
);
  import mfc_pkg::*;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rts <= 1'b0;
      ie  <= 1'b0;
    end else if (wr) begin
      rts <= wdata[BIT_RTS];
      ie  <= wdata[BIT_IE];
    end

  a_r8_ctrl_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(rts) && $stable(ie)));
endmodule

// File: rtl/mfc_regs.sv
module mfc_regs #(
  parameter bit FLOW_EN     = 1'b1,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cts_n,
  output logic              rts_n,
  output logic              irq,
  input  logic              host_wr,
  input  logic              host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata
);
  import mfc_pkg::*;

  if (FLOW_EN) begin : g_on
    logic cts_n_sync, dcts, rts, ie;
    logic wr_stat, wr_ctrl;
    logic [DATA_W-1:0] stat_word, ctrl_word;
    logic unused_wdata;

    assign wr_stat = host_wr && (host_addr == ADDR_STATUS);
    assign wr_ctrl = host_wr && (host_addr == ADDR_CTRL);
    assign unused_wdata = ^host_wdata;

    mfc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(cts_n), .q(cts_n_sync));

    mfc_delta u_delta (
      .clk(clk), .rst_n(rst_n), .level(cts_n_sync), .clr(wr_stat), .flag(dcts));

    mfc_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr(wr_ctrl), .wdata(host_wdata),
      .rts(rts), .ie(ie));

    always_comb begin
      stat_word = '0;
      stat_word[BIT_CTS]  = ~cts_n_sync;
      stat_word[BIT_DCTS] = dcts;
      ctrl_word = '0;
      ctrl_word[BIT_RTS]  = rts;
      ctrl_word[BIT_IE]   = ie;
    end

    assign host_rdata = (host_addr == ADDR_CTRL) ? ctrl_word : stat_word;
    assign rts_n      = ~rts;
    assign irq        = dcts & ie;

    a_r6_rts_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (rts_n == !$past(host_wdata[BIT_RTS])));
    a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      !ie |-> !irq);
  end else begin : g_off
    logic unused_in;
    assign unused_in  = ^{clk, rst_n, cts_n, host_wr, host_addr, host_wdata};
    assign host_rdata = '0;
    assign rts_n      = 1'b1;
    assign irq        = 1'b0;
  end
endmodule

// File: tb/mfc_regs_tb.sv
module mfc_regs_tb;
  localparam int DW = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cts_n = 1'b1, host_wr = 1'b0, host_addr = 1'b0;
  logic [DW-1:0] host_wdata = '0;
  logic rts_n, irq, off_rts_n, off_irq;
  logic [DW-1:0] host_rdata, off_rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mfc_regs #(.FLOW_EN(1'b1), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .rts_n(rts_n), .irq(irq),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata));

  mfc_regs #(.FLOW_EN(1'b0), .DATA_W(DW)) u_off (
    .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .rts_n(off_rts_n), .irq(off_irq),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(off_rdata));

  // bench model of the requirements
  logic m_s1, m_s2, m_prev, m_dcts, m_rts, m_ie;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_s1 <= 1; m_s2 <= 1; m_prev <= 1; m_dcts <= 0; m_rts <= 0; m_ie <= 0;
    end else begin
      m_s1 <= cts_n; m_s2 <= m_s1; m_prev <= m_s2;
      if (m_s2 != m_prev) m_dcts <= 1;                  // R3
      else if (host_wr && !host_addr) m_dcts <= 0;      // R4
      if (host_wr && host_addr) begin                   // R5
        m_rts <= host_wdata[0]; m_ie <= host_wdata[1];
      end
    end

  function automatic logic [DW-1:0] exp_read(logic a);
    logic [DW-1:0] v = '0;
    if (a) begin v[0] = m_rts; v[1] = m_ie; end
    else   begin v[0] = ~m_s2; v[1] = m_dcts; end
    return v;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(logic w, logic a, logic [DW-1:0] d);
    @(negedge clk);
    host_wr = w; host_addr = a; host_wdata = d;
  endtask

  task automatic rd(logic a, logic [DW-1:0] e, string tag);
    host_wr = 0; host_addr = a; #1;
    chk(host_rdata === e, tag, host_rdata, e);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    rd(0, 8'h00, "R1 status"); rd(1, 8'h00, "R1 control");
    chk(rts_n === 1'b1, "R1 rts_n", rts_n, 1);
    chk(irq === 1'b0, "R1 irq", irq, 0);

    // R5/R6 control write and readback
    drive(1, 1, 8'hFF); @(negedge clk); host_wr = 0; #1;
    rd(1, 8'h03, "R5 ctrl readback masks upper bits");
    chk(rts_n === 1'b0, "R6 rts_n low after RTS=1", rts_n, 0);

    // R2/R3 latency of a falling pin
    cts_n = 0;
    @(negedge clk); rd(0, 8'h00, "R2 no change after 1 edge");
    @(negedge clk); rd(0, 8'h01, "R2 CTS after 2 edges");
    chk(irq === 1'b0, "R7 irq not yet", irq, 0);
    @(negedge clk); rd(0, 8'h03, "R3 DCTS after 3 edges");
    chk(irq === 1'b1, "R7 irq with enable", irq, 1);

    // R8 control write leaves DCTS; disable irq
    drive(1, 1, 8'h01); @(negedge clk); host_wr = 0; #1;
    rd(0, 8'h03, "R8 ctrl write keeps DCTS");
    chk(irq === 1'b0, "R7 irq off with enable 0", irq, 0);

    // R4 status write clears regardless of data, R8 control unchanged
    drive(1, 0, 8'h00); @(negedge clk); host_wr = 0; #1;
    rd(0, 8'h01, "R4 DCTS cleared by status write");
    rd(1, 8'h01, "R8 status write keeps control");

    // R3 rising pin, R4 change on same edge as clear keeps flag
    cts_n = 1;
    @(negedge clk); @(negedge clk); rd(0, 8'h00, "R2 CTS off after 2 edges");
    host_wr = 1; host_addr = 0;   // clear write lands on the detect edge
    @(negedge clk); host_wr = 0; #1;
    rd(0, 8'h02, "R4 change wins over same-edge clear");
    drive(1, 0, 8'h55); @(negedge clk); host_wr = 0; #1;
    rd(0, 8'h00, "R4 cleared later");

    // random traffic against model, plus disabled instance
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if ($urandom_range(7) == 0) cts_n = ~cts_n;
      host_wr = ($urandom_range(3) == 0);
      host_addr = $urandom_range(1);
      host_wdata = DW'($urandom);
      #1;
      chk(host_rdata === exp_read(host_addr), "R2/R3/R4/R5 random read",
          host_rdata, exp_read(host_addr));
      chk(rts_n === ~m_rts, "R6 random rts_n", rts_n, ~m_rts);
      chk(irq === (m_dcts & m_ie), "R7 random irq", irq, m_dcts & m_ie);
      chk(off_rdata === '0 && off_rts_n === 1'b1 && off_irq === 1'b0,
          "R9 disabled outputs", {off_irq, off_rts_n, off_rdata}, 9'h100);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule